// File: doc/BRIEF.md
# Calendar Cell-Slot Scheduler

This block chooses which virtual circuit may send a cell in each transmit cell slot. It keeps up to 32 circuits. Each circuit has an inter-cell spacing, a priority level from 0 to 3 and a rate-cell interval, all held in a small per-circuit table. A ring of 64 future slots holds the circuits that are waiting to send. On each slot strobe the circuits due in the current slot compete by priority. The winner is granted and put back into the ring at the current slot plus its spacing. The others that are still due move on to the next slot.

The host loads a circuit's parameters through a single write port. It starts and stops a circuit's data flow with activate and stop strobes. A separate update port takes rate feedback and rewrites one circuit's spacing while that circuit is running. For circuits under rate control, every k-th grant is flagged as a forward rate-management cell instead of a data cell. One cycle after each slot strobe the block returns either a grant with the circuit index or an idle indication.

Top module: `cell_slot_sched`

## Requirements
- R1: While reset is held, and after it is released until the first slot strobe, neither `grant_valid` nor `slot_idle` is asserted. Every circuit starts with spacing 1, priority 0, rate cells disabled and no data pending.
- R2: Each `slot_tick` produces exactly one result in the next cycle: either `grant_valid` or `slot_idle` for one cycle. No result appears without a strobe. `slot_idle` marks a slot in which no pending circuit was due.
- R3: An activated circuit that is not already in the ring becomes due at the next slot strobe. When the activation arrives in the same cycle as a strobe, it becomes due at the strobe after that one.
- R4: A circuit granted in slot p is next due in slot (p + spacing) mod 64. A spacing of 0 is stored as 1.
- R5: Among the circuits due in a slot, the higher priority value (3 highest) wins, and ties go to the lowest circuit index. Circuits that lose stay due in the following slot.
- R6: A stopped circuit that comes due is removed from the ring without a grant. It is not granted again until it is activated again.
- R7: A rate update replaces the circuit's spacing (0 stored as 1) and first takes effect at that circuit's next reschedule. A grant issued in the same cycle as the update is rescheduled with the old spacing.
- R8: With a rate-cell interval k (4 bits, 0 meaning disabled), every k-th grant of the circuit is flagged by `grant_frm`. Writing the circuit's configuration restarts this count.
- R9: A configuration write sets spacing, priority and rate-cell interval together for the addressed circuit. It does not change whether the circuit is pending or in the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_vc | input | 5 | Circuit being configured |
| cfg_spacing | input | 6 | Inter-cell spacing in slots |
| cfg_prio | input | 2 | Priority level, 3 highest |
| cfg_frm_every | input | 4 | Rate-cell interval k, 0 disables |
| act_valid | input | 1 | Mark circuit as having data |
| act_vc | input | 5 | Circuit to activate |
| stop_valid | input | 1 | Mark circuit as having no data |
| stop_vc | input | 5 | Circuit to stop |
| rate_valid | input | 1 | Rate feedback update strobe |
| rate_vc | input | 5 | Circuit whose spacing is updated |
| rate_spacing | input | 6 | New spacing |
| slot_tick | input | 1 | One cell slot elapses |
| grant_valid | output | 1 | A circuit is granted this slot |
| grant_vc | output | 5 | Granted circuit index |
| grant_frm | output | 1 | Grant is a forward rate cell |
| slot_idle | output | 1 | No circuit was granted this slot |

## Verification
Every result is due exactly one clock after its strobe, because the grant registers are the only stage between the ring read and the ports. Configuration, activation, stop and rate writes are visible to a strobe issued one cycle later. For each strobe the driver computes the expected grant, rate-cell flag or idle from a countdown model of per-circuit waits. The model has no ring. The monitor compares each pulse with the oldest queued item on the falling edge that follows, so every comparison lands in the single cycle the result is valid. The queue must be empty at the end, which catches missing results as well as extra ones.

// File: rtl/cell_slot_sched_pkg.sv
package cell_slot_sched_pkg;
   localparam int PRIO_W = 2;
   typedef logic [PRIO_W-1:0] prio_t;

   function automatic int clog2_min1(input int n);
      int r;
      r = 0;
      while ((1 << r) < n) r++;
      return (r < 1) ? 1 : r;
   endfunction
endpackage

// File: rtl/sched_vc_table.sv
module sched_vc_table
   import cell_slot_sched_pkg::*;
#(
   parameter int NUM_VC = 32,
   parameter int SP_W   = 6,
   parameter int K_W    = 4,
   localparam int VC_W  = clog2_min1(NUM_VC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [VC_W-1:0]          cfg_vc,
   input  logic [SP_W-1:0]          cfg_sp,
   input  prio_t                    cfg_prio,
   input  logic [K_W-1:0]           cfg_k,
   input  logic                     rate_valid,
   input  logic [VC_W-1:0]          rate_vc,
   input  logic [SP_W-1:0]          rate_sp,
   input  logic                     act_valid,
   input  logic [VC_W-1:0]          act_vc,
   input  logic                     stop_valid,
   input  logic [VC_W-1:0]          stop_vc,
   input  logic                     win_valid,
   input  logic [VC_W-1:0]          win_vc,
   input  logic [NUM_VC-1:0]        place_mask,
   input  logic [NUM_VC-1:0]        drop_mask,
   output logic [NUM_VC*PRIO_W-1:0] prio_flat,
   output logic [NUM_VC-1:0]        pend_vec,
   output logic [NUM_VC-1:0]        incal_vec,
   output logic [SP_W-1:0]          win_sp,
   output logic                     win_frm
);
   logic [SP_W-1:0] sp_a  [NUM_VC];
   logic [K_W-1:0]  k_a   [NUM_VC];
   logic [K_W-1:0]  cnt_a [NUM_VC];

   logic [SP_W-1:0] cfg_sp_fix, rate_sp_fix;
   assign cfg_sp_fix  = (cfg_sp  == '0) ? SP_W'(1) : cfg_sp;
   assign rate_sp_fix = (rate_sp == '0) ? SP_W'(1) : rate_sp;

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      logic [SP_W-1:0] sp_q;
      prio_t           pr_q;
      logic [K_W-1:0]  k_q, cnt_q;
      logic            pend_q, incal_q;
      logic            hit_cfg, hit_rate, hit_win;

      assign hit_cfg  = cfg_we     && (cfg_vc  == VC_W'(v));
      assign hit_rate = rate_valid && (rate_vc == VC_W'(v));
      assign hit_win  = win_valid  && (win_vc  == VC_W'(v));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sp_q    <= SP_W'(1);
            pr_q    <= '0;
            k_q     <= '0;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            incal_q <= 1'b0;
         end else begin
            if (hit_cfg) begin
               sp_q <= cfg_sp_fix;
               pr_q <= cfg_prio;
               k_q  <= cfg_k;
            end else if (hit_rate) begin
               sp_q <= rate_sp_fix;
            end

            if (hit_cfg) begin
               cnt_q <= '0;
            end else if (hit_win && (k_q != '0)) begin
               cnt_q <= ((cnt_q + K_W'(1)) == k_q) ? '0 : cnt_q + K_W'(1);
            end

            if (act_valid && (act_vc == VC_W'(v))) begin
               pend_q <= 1'b1;
            end else if (stop_valid && (stop_vc == VC_W'(v))) begin
               pend_q <= 1'b0;
            end

            if (place_mask[v]) begin
               incal_q <= 1'b1;
            end else if (drop_mask[v]) begin
               incal_q <= 1'b0;
            end
         end
      end

      assign sp_a[v]  = sp_q;
      assign k_a[v]   = k_q;
      assign cnt_a[v] = cnt_q;
      assign prio_flat[v*PRIO_W +: PRIO_W] = pr_q;
      assign pend_vec[v]  = pend_q;
      assign incal_vec[v] = incal_q;
   end

   assign win_sp  = sp_a[win_vc];
   assign win_frm = (k_a[win_vc] != '0) && ((cnt_a[win_vc] + K_W'(1)) == k_a[win_vc]);
endmodule

// File: rtl/sched_arbiter.sv
module sched_arbiter
   import cell_slot_sched_pkg::*;
#(
   parameter int NUM_VC = 32,
   localparam int VC_W  = clog2_min1(NUM_VC)
) (
   input  logic [NUM_VC-1:0]        req,
   input  logic [NUM_VC*PRIO_W-1:0] prio_flat,
   output logic                     found,
   output logic [VC_W-1:0]          win
);
   prio_t best_p;

   always_comb begin
      found  = 1'b0;
      win    = '0;
      best_p = '0;
      for (int i = 0; i < NUM_VC; i++) begin
         if (req[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] > best_p))) begin
            found  = 1'b1;
            win    = VC_W'(i);
            best_p = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/sched_calendar.sv
module sched_calendar #(
   parameter int NUM_VC = 32,
   parameter int SLOTS  = 64,
   parameter int SP_W   = 6,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int VC_W   = $clog2(NUM_VC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [NUM_VC-1:0] carry,
   input  logic              res_valid,
   input  logic [VC_W-1:0]   res_vc,
   input  logic [SP_W-1:0]   res_sp,
   input  logic              place_valid,
   input  logic [VC_W-1:0]   place_vc,
   output logic [NUM_VC-1:0] cur_row
);
   logic [NUM_VC-1:0] cal_q [SLOTS];
   logic [NUM_VC-1:0] cal_d [SLOTS];
   logic [SLOT_W-1:0] ptr_q, next_slot, res_slot, place_slot;

   assign next_slot  = ptr_q + SLOT_W'(1);
   assign res_slot   = ptr_q + SLOT_W'(res_sp);
   assign place_slot = tick ? next_slot : ptr_q;
   assign cur_row    = cal_q[ptr_q];

   always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
         cal_d[s] = cal_q[s];
         if (tick && (SLOT_W'(s) == ptr_q))
            cal_d[s] = '0;
         if (tick && (SLOT_W'(s) == next_slot))
            cal_d[s] = cal_d[s] | carry;
         if (res_valid && (SLOT_W'(s) == res_slot))
            cal_d[s] = cal_d[s] | (NUM_VC'(1) << res_vc);
         if (place_valid && (SLOT_W'(s) == place_slot))
            cal_d[s] = cal_d[s] | (NUM_VC'(1) << place_vc);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         for (int s = 0; s < SLOTS; s++) cal_q[s] <= '0;
      end else begin
         if (tick) ptr_q <= next_slot;
         for (int s = 0; s < SLOTS; s++) cal_q[s] <= cal_d[s];
      end
   end
endmodule

// File: rtl/cell_slot_sched.sv
module cell_slot_sched
   import cell_slot_sched_pkg::*;
#(
   parameter int NUM_VC    = 32,
   parameter int CAL_SLOTS = 64,
   parameter int SP_W      = 6,
   parameter int K_W       = 4,
   localparam int VC_W     = clog2_min1(NUM_VC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [VC_W-1:0] cfg_vc,
   input  logic [SP_W-1:0] cfg_spacing,
   input  logic [1:0]      cfg_prio,
   input  logic [K_W-1:0]  cfg_frm_every,
   input  logic            act_valid,
   input  logic [VC_W-1:0] act_vc,
   input  logic            stop_valid,
   input  logic [VC_W-1:0] stop_vc,
   input  logic            rate_valid,
   input  logic [VC_W-1:0] rate_vc,
   input  logic [SP_W-1:0] rate_spacing,
   input  logic            slot_tick,
   output logic            grant_valid,
   output logic [VC_W-1:0] grant_vc,
   output logic            grant_frm,
   output logic            slot_idle
);
   if (NUM_VC < 2 || (1 << VC_W) != NUM_VC)
      $error("NUM_VC must be a power of two of at least 2");
   if (CAL_SLOTS < 2 || (1 << $clog2(CAL_SLOTS)) != CAL_SLOTS)
      $error("CAL_SLOTS must be a power of two of at least 2");
   if (SP_W > $clog2(CAL_SLOTS))
      $error("spacing must stay below one calendar turn");
   if (K_W < 1)
      $error("rate-cell interval needs at least one bit");

   logic [NUM_VC*PRIO_W-1:0] prio_flat;
   logic [NUM_VC-1:0] pend_vec, incal_vec, row, req, drop, carry, win_oh, place_mask;
   logic              found, place_valid, win_frm;
   logic [VC_W-1:0]   win;
   logic [SP_W-1:0]   win_sp;

   assign req        = row & pend_vec;
   assign drop       = slot_tick ? (row & ~pend_vec) : '0;
   assign win_oh     = found ? (NUM_VC'(1) << win) : '0;
   assign carry      = req & ~win_oh;
   assign place_valid = act_valid && (!incal_vec[act_vc] || drop[act_vc]);
   assign place_mask = place_valid ? (NUM_VC'(1) << act_vc) : '0;

   sched_arbiter #(.NUM_VC(NUM_VC)) u_arb (
      .req(req), .prio_flat(prio_flat), .found(found), .win(win)
   );

   sched_vc_table #(.NUM_VC(NUM_VC), .SP_W(SP_W), .K_W(K_W)) u_tab (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_vc(cfg_vc), .cfg_sp(cfg_spacing),
      .cfg_prio(prio_t'(cfg_prio)), .cfg_k(cfg_frm_every),
      .rate_valid(rate_valid), .rate_vc(rate_vc), .rate_sp(rate_spacing),
      .act_valid(act_valid), .act_vc(act_vc),
      .stop_valid(stop_valid), .stop_vc(stop_vc),
      .win_valid(slot_tick && found), .win_vc(win),
      .place_mask(place_mask), .drop_mask(drop),
      .prio_flat(prio_flat), .pend_vec(pend_vec), .incal_vec(incal_vec),
      .win_sp(win_sp), .win_frm(win_frm)
   );

   sched_calendar #(.NUM_VC(NUM_VC), .SLOTS(CAL_SLOTS), .SP_W(SP_W)) u_cal (
      .clk(clk), .rst_n(rst_n), .tick(slot_tick), .carry(carry),
      .res_valid(slot_tick && found), .res_vc(win), .res_sp(win_sp),
      .place_valid(place_valid), .place_vc(act_vc), .cur_row(row)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_vc    <= '0;
         grant_frm   <= 1'b0;
         slot_idle   <= 1'b0;
      end else begin
         grant_valid <= slot_tick && found;
         grant_vc    <= win;
         grant_frm   <= slot_tick && found && win_frm;
         slot_idle   <= slot_tick && !found;
      end
   end
endmodule

// File: rtl/cell_slot_sched_chk.sv
module cell_slot_sched_chk #(
   parameter int NUM_VC = 32,
   parameter int VC_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slot_tick,
   input logic              grant_valid,
   input logic [VC_W-1:0]   grant_vc,
   input logic              grant_frm,
   input logic              slot_idle,
   input logic [NUM_VC-1:0] pend_vec
);
   logic [NUM_VC-1:0] pend_prev;
   always_ff @(posedge clk) begin
      if (!rst_n) pend_prev <= '0;
      else        pend_prev <= pend_vec;
   end

   AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_valid && slot_idle)); // R2
   AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick |=> (grant_valid || slot_idle)); // R2
   AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_tick |=> !(grant_valid || slot_idle)); // R2
   AST_FRM_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      grant_frm |-> grant_valid); // R8
   AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> pend_prev[grant_vc]); // R6
endmodule

bind cell_slot_sched cell_slot_sched_chk #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .grant_valid(grant_valid),
   .grant_vc(grant_vc), .grant_frm(grant_frm), .slot_idle(slot_idle),
   .pend_vec(pend_vec)
);

// File: tb/cell_slot_sched_test.sv
module cell_slot_sched_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, act_valid = 0, stop_valid = 0, rate_valid = 0, slot_tick = 0;
   logic [4:0] cfg_vc = 0, act_vc = 0, stop_vc = 0, rate_vc = 0;
   logic [5:0] cfg_spacing = 0, rate_spacing = 0;
   logic [1:0] cfg_prio = 0;
   logic [3:0] cfg_frm_every = 0;
   logic grant_valid, grant_frm, slot_idle;
   logic [4:0] grant_vc;

   int checks = 0;
   int errors = 0;

   typedef struct { bit idle; int vc; bit frm; string tag; } exp_t;
   exp_t expq[$];

   int m_sp[32], m_pr[32], m_k[32], m_cnt[32], m_wait[32];
   bit m_pend[32], m_incal[32];

   always #10 clk = ~clk;

   cell_slot_sched uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_vc(cfg_vc),
      .cfg_spacing(cfg_spacing), .cfg_prio(cfg_prio), .cfg_frm_every(cfg_frm_every),
      .act_valid(act_valid), .act_vc(act_vc), .stop_valid(stop_valid), .stop_vc(stop_vc),
      .rate_valid(rate_valid), .rate_vc(rate_vc), .rate_spacing(rate_spacing),
      .slot_tick(slot_tick), .grant_valid(grant_valid), .grant_vc(grant_vc),
      .grant_frm(grant_frm), .slot_idle(slot_idle)
   );

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic check(input bit ok, input string tag, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s", tag, what);
      end
   endtask

   // monitor: compare every result pulse with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && (grant_valid || slot_idle)) begin
         if (expq.size() == 0) begin
            check(0, "R2", $sformatf("unexpected result actual grant=%0b vc=%0d idle=%0b expected none",
                  grant_valid, grant_vc, slot_idle));
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (e.idle)
               check(slot_idle && !grant_valid, e.tag,
                     $sformatf("actual grant=%0b vc=%0d idle=%0b expected idle",
                               grant_valid, grant_vc, slot_idle));
            else
               check(grant_valid && grant_vc == 5'(e.vc) && grant_frm == e.frm, e.tag,
                     $sformatf("actual grant=%0b vc=%0d frm=%0b expected vc=%0d frm=%0b",
                               grant_valid, grant_vc, grant_frm, e.vc, e.frm));
         end
      end
   end

   function automatic int fix_sp(input int s);
      return (s == 0) ? 1 : s;
   endfunction

   function automatic void model_tick(input string tag);
      int best;
      exp_t e;
      best = -1;
      for (int v = 0; v < 32; v++) begin
         if (m_incal[v] && m_wait[v] == 0) begin
            if (!m_pend[v]) m_incal[v] = 0;
            else if (best < 0 || m_pr[v] > m_pr[best]) best = v;
         end
      end
      for (int v = 0; v < 32; v++)
         if (m_incal[v] && v != best && m_wait[v] > 0) m_wait[v]--;
      e.tag = tag;
      if (best >= 0) begin
         e.idle = 0; e.vc = best; e.frm = 0;
         m_wait[best] = m_sp[best] - 1;
         if (m_k[best] != 0) begin
            m_cnt[best]++;
            if (m_cnt[best] == m_k[best]) begin e.frm = 1; m_cnt[best] = 0; end
         end
      end else begin
         e.idle = 1; e.vc = 0; e.frm = 0;
      end
      expq.push_back(e);
   endfunction

   function automatic void model_act(input int vc);
      m_pend[vc] = 1;
      if (!m_incal[vc]) begin m_incal[vc] = 1; m_wait[vc] = 0; end
   endfunction

   task automatic cycle_end();
      @(negedge clk);
      cfg_we = 0; act_valid = 0; stop_valid = 0; rate_valid = 0; slot_tick = 0;
   endtask

   task automatic do_cfg(input int vc, input int sp, input int pr, input int k);
      cfg_we = 1; cfg_vc = 5'(vc); cfg_spacing = 6'(sp); cfg_prio = 2'(pr); cfg_frm_every = 4'(k);
      m_sp[vc] = fix_sp(sp); m_pr[vc] = pr; m_k[vc] = k; m_cnt[vc] = 0;
      cycle_end();
   endtask

   task automatic do_act(input int vc);
      act_valid = 1; act_vc = 5'(vc);
      model_act(vc);
      cycle_end();
   endtask

   task automatic do_stop(input int vc);
      stop_valid = 1; stop_vc = 5'(vc);
      m_pend[vc] = 0;
      cycle_end();
   endtask

   task automatic do_rate(input int vc, input int sp);
      rate_valid = 1; rate_vc = 5'(vc); rate_spacing = 6'(sp);
      m_sp[vc] = fix_sp(sp);
      cycle_end();
   endtask

   task automatic do_tick(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         slot_tick = 1;
         model_tick(tag);
         cycle_end();
      end
   endtask

   task automatic tick_rate(input int vc, input int sp, input string tag);
      slot_tick = 1; rate_valid = 1; rate_vc = 5'(vc); rate_spacing = 6'(sp);
      model_tick(tag);
      m_sp[vc] = fix_sp(sp);
      cycle_end();
   endtask

   task automatic tick_act(input int vc, input string tag);
      slot_tick = 1; act_valid = 1; act_vc = 5'(vc);
      model_tick(tag);
      model_act(vc);
      cycle_end();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int v = 0; v < 32; v++) begin
         m_sp[v] = 1; m_pr[v] = 0; m_k[v] = 0; m_cnt[v] = 0;
         m_wait[v] = 0; m_pend[v] = 0; m_incal[v] = 0;
      end
      repeat (4) @(negedge clk);
      check(!grant_valid && !slot_idle, "R1",
            $sformatf("in reset actual grant=%0b idle=%0b expected 0 0", grant_valid, slot_idle));
      rst_n = 1;
      @(negedge clk);
      check(!grant_valid && !slot_idle, "R1",
            $sformatf("after reset actual grant=%0b idle=%0b expected 0 0", grant_valid, slot_idle));

      do_tick(2, "R2");
      // R9: defaults and configured parameters
      do_act(20);
      do_tick(3, "R9");
      do_stop(20);
      do_tick(2, "R6");

      do_cfg(3, 4, 1, 0);
      do_act(3);
      do_tick(9, "R4");
      do_rate(3, 2);
      do_tick(8, "R7");
      do_tick(1, "R7");
      tick_rate(3, 5, "R7");
      do_tick(12, "R7");
      do_stop(3);
      do_tick(8, "R6");
      do_act(3);
      do_tick(3, "R6");
      do_stop(3);
      do_tick(6, "R6");

      do_cfg(5, 2, 2, 0);
      do_cfg(7, 2, 2, 0);
      do_cfg(1, 1, 0, 0);
      do_act(7); do_act(1); do_act(5);
      do_tick(6, "R5");
      do_stop(5); do_stop(7);
      do_tick(5, "R5");
      do_stop(1);
      do_tick(3, "R6");

      do_cfg(9, 1, 3, 3);
      do_act(9);
      do_tick(7, "R8");
      do_cfg(9, 1, 3, 3);
      do_tick(4, "R8");
      do_cfg(9, 1, 3, 0);
      do_tick(2, "R8");
      do_stop(9);
      do_tick(3, "R6");

      do_cfg(12, 0, 0, 0);
      do_act(12);
      do_tick(3, "R4");
      do_cfg(12, 63, 0, 0);
      do_tick(130, "R4");
      do_stop(12);
      do_tick(64, "R6");

      tick_act(14, "R3");
      do_tick(3, "R3");
      do_stop(14);
      do_tick(3, "R6");

      repeat (3) @(negedge clk);
      check(expq.size() == 0, "R2",
            $sformatf("pending results actual %0d expected 0", expq.size()));
      finish_run();
   end
endmodule